// File: doc/BRIEF.md
# Protected Paged Memory Mapper

This block turns a 16-bit CPU logical address into a wide physical address by looking up a 16-bit physical page number in a bank of page registers. Four independent register sets (maps) exist. A map-select input picks the set used for translation. The top three logical address bits pick one of the eight registers in that set. The physical address is the page number with the 13-bit offset of an 8 KB page appended to it.

The CPU reaches the registers through one memory-mapped window per map, using whole-word or single-byte writes.

- User-mode code sees a packed view: the low bytes of two adjacent page registers share one bus word.
- Supervisor code can also reach each register as a full 16-bit word.
- Supervisor code can set a per-map slice size, given as a power-of-two exponent. This size bounds the page numbers that user code may write.
- A user write that breaks a rule is dropped, and the bus-error output pulses during the offending write strobe.

Top module: `page_mapper`

## Requirements
- R1: After reset, every page register of every map is 0 and every map's slice exponent is 0, so only page 0 is open to user writes.
- R2: `paddr` equals {page register `laddr[15:13]` of map `map_sel`, `laddr[12:0]`}. A committed register write is visible in `paddr` from the cycle after its strobe.
- R3: Window words 0 to 3 form the packed view. In word k, bits 15:8 are the low byte of page register 2k and bits 7:0 are the low byte of page register 2k+1. A write with both byte strobes updates both registers.
- R4: A single-byte write to a packed word, through `io_be[1]` for the high lane or `io_be[0]` for the low lane, merges into the current word. The register behind the other lane keeps its value.
- R5: A user-mode write never changes bits 15:8 of any page register. A user-mode read of window words 8 to 15 returns 0.
- R6: With slice exponent n, a user write whose written byte has a 1 at page bit n or above raises `bus_err` in the cycle of the write strobe. Neither register of that word changes. A byte with no such bit commits without error.
- R7: Supervisor writes ignore the slice limit. Window word 8+i holds the full 16-bit page register i, and each byte lane updates the matching half.
- R8: A user write to window words 8 to 16 raises `bus_err` and changes nothing.
- R9: Window word 16 holds the map's slice exponent in bits 4:0. A supervisor write takes it from `io_wdata[7:0]` through the low lane, and values above 16 saturate to 16. Exponent 16 leaves no page bit protected.
- R10: A write through the window of map `io_map` changes only that map's registers. `map_sel` alone chooses the set used for translation.
- R11: `bus_err` is low in every cycle without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup | input | 1 | 1 when the current bus access is privileged |
| io_wr | input | 1 | Write strobe for the register window |
| io_map | input | 2 | Map whose window is accessed |
| io_addr | input | 5 | Word address inside the window |
| io_be | input | 2 | Byte lanes: bit 1 covers data 15:8, bit 0 covers data 7:0 |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data for the addressed window word (combinational) |
| bus_err | output | 1 | Pulses during a rejected write strobe |
| map_sel | input | 2 | Map used for translation |
| laddr | input | 16 | Logical address |
| paddr | output | 29 | Physical address |

## Verification
The bench goes after the lane merge of packed byte writes. A design that writes the whole word would clear the neighbouring register, and one with swapped lanes would update the wrong page. Masked-bit writes are aimed at the exact exponent boundary: a wrong comparison either lets a protected bit through or faults a legal byte, and a design that commits before checking corrupts the other half of the word. Supervisor override of the upper byte and user writes to privileged words show whether privilege is enforced at all. Writing through one map's window and then reading and translating through the others exposes cross-map leakage or a translation path that follows the window instead of `map_sel`.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int NUM_MAPS  = 4;
    localparam int MAP_W     = $clog2(NUM_MAPS);
    localparam int LA_W      = 16;
    localparam int PG_W      = 16;
    localparam int PAGE_OFF  = 13;
    localparam int PIDX_W    = LA_W - PAGE_OFF;
    localparam int PAGES     = 1 << PIDX_W;
    localparam int PA_W      = PG_W + PAGE_OFF;
    localparam int WIN_AW    = PIDX_W + 2;
    localparam int BUS_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int FULL_BASE = PAGES;
    localparam int MASK_WORD = 2 * PAGES;
    localparam int EXP_W     = $clog2(PG_W + 1);

    typedef logic [PG_W-1:0] page_t;
    typedef logic [PAGES-1:0][PG_W-1:0] map_pages_t;

    typedef enum logic [1:0] {
        RG_PACK,
        RG_FULL,
        RG_MASK,
        RG_NONE
    } region_e;

    typedef struct packed {
        logic              commit;
        logic [MAP_W-1:0]  map;
        logic [PAGES-1:0]  pg_we;
        logic              mask_we;
        logic [EXP_W-1:0]  mask_val;
    } wr_cmd_t;

    // bits a user may not set for a given slice exponent
    function automatic page_t prot_bits(input logic [EXP_W-1:0] e);
        page_t open_bits;
        open_bits = (page_t'(1) << e) - page_t'(1);
        return ~open_bits;
    endfunction

    function automatic logic [EXP_W-1:0] sat_exp(input logic [BYTE_W-1:0] v);
        if (int'(v) > PG_W)
            return EXP_W'(PG_W);
        return v[EXP_W-1:0];
    endfunction

    function automatic region_e decode_region(input logic [WIN_AW-1:0] a);
        if (int'(a) < PAGES / 2)
            return RG_PACK;
        if (int'(a) >= FULL_BASE && int'(a) < FULL_BASE + PAGES)
            return RG_FULL;
        if (int'(a) == MASK_WORD)
            return RG_MASK;
        return RG_NONE;
    endfunction

endpackage

// File: rtl/mmap_access.sv
module mmap_access
    import mmap_pkg::*;
(
    input  logic                io_wr,
    input  logic                sup,
    input  logic [1:0]          io_be,
    input  logic [MAP_W-1:0]    io_map,
    input  logic [WIN_AW-1:0]   io_addr,
    input  logic [BUS_W-1:0]    io_wdata,
    input  map_pages_t          cur_pages,
    input  logic [EXP_W-1:0]    cur_exp,
    output wr_cmd_t             cmd,
    output map_pages_t          nxt_pages,
    output logic [BUS_W-1:0]    io_rdata,
    output logic                bus_err
);

    region_e            region;
    page_t              prot;
    logic [PIDX_W-1:0]  full_idx;
    logic [PIDX_W-1:0]  hi_idx;
    logic [PIDX_W-1:0]  lo_idx;
    logic [BYTE_W-1:0]  hi_byte;
    logic [BYTE_W-1:0]  lo_byte;
    logic [PAGES-1:0]   we;
    logic               viol;
    logic               mask_we;
    logic [EXP_W-1:0]   mask_val;

    assign region   = decode_region(io_addr);
    assign prot     = prot_bits(cur_exp);
    assign full_idx = io_addr[PIDX_W-1:0];
    assign hi_idx   = {io_addr[PIDX_W-2:0], 1'b0};
    assign lo_idx   = {io_addr[PIDX_W-2:0], 1'b1};
    assign hi_byte  = io_wdata[BUS_W-1:BYTE_W];
    assign lo_byte  = io_wdata[BYTE_W-1:0];

    // merge written lanes into the current contents and judge the access
    always_comb begin
        nxt_pages = cur_pages;
        we        = '0;
        viol      = 1'b0;
        mask_we   = 1'b0;
        mask_val  = cur_exp;
        case (region)
            RG_PACK: begin
                if (io_be[1]) begin
                    nxt_pages[hi_idx][BYTE_W-1:0] = hi_byte;
                    we[hi_idx] = 1'b1;
                    if (!sup && ((page_t'(hi_byte) & prot) != '0))
                        viol = 1'b1;
                end
                if (io_be[0]) begin
                    nxt_pages[lo_idx][BYTE_W-1:0] = lo_byte;
                    we[lo_idx] = 1'b1;
                    if (!sup && ((page_t'(lo_byte) & prot) != '0))
                        viol = 1'b1;
                end
            end
            RG_FULL: begin
                if (!sup && (io_be != 2'b00))
                    viol = 1'b1;
                if (io_be[1])
                    nxt_pages[full_idx][PG_W-1:BYTE_W] = hi_byte;
                if (io_be[0])
                    nxt_pages[full_idx][BYTE_W-1:0] = lo_byte;
                we[full_idx] = |io_be;
            end
            RG_MASK: begin
                if (!sup && (io_be != 2'b00))
                    viol = 1'b1;
                if (io_be[0]) begin
                    mask_we  = 1'b1;
                    mask_val = sat_exp(lo_byte);
                end
            end
            default: begin
            end
        endcase
    end

    assign bus_err      = io_wr && viol;
    assign cmd.commit   = io_wr && !viol;
    assign cmd.map      = io_map;
    assign cmd.pg_we    = we;
    assign cmd.mask_we  = mask_we;
    assign cmd.mask_val = mask_val;

    always_comb begin
        io_rdata = '0;
        case (region)
            RG_PACK: io_rdata = {cur_pages[hi_idx][BYTE_W-1:0],
                                 cur_pages[lo_idx][BYTE_W-1:0]};
            RG_FULL: io_rdata = sup ? cur_pages[full_idx] : '0;
            RG_MASK: io_rdata = BUS_W'(cur_exp);
            default: io_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mmap_store.sv
module mmap_store
    import mmap_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  wr_cmd_t                             cmd,
    input  map_pages_t                          nxt_pages,
    output map_pages_t [NUM_MAPS-1:0]           pages_o,
    output logic [NUM_MAPS-1:0][EXP_W-1:0]      exp_o
);

    for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
        map_pages_t         pg_r;
        logic [EXP_W-1:0]   ex_r;
        logic               hit;

        assign hit = cmd.commit && (cmd.map == MAP_W'(m));

        always_ff @(posedge clk) begin
            if (rst) begin
                pg_r <= '0;
                ex_r <= '0;
            end else if (hit) begin
                for (int p = 0; p < PAGES; p++) begin
                    if (cmd.pg_we[p])
                        pg_r[p] <= nxt_pages[p];
                end
                if (cmd.mask_we)
                    ex_r <= cmd.mask_val;
            end
        end

        assign pages_o[m] = pg_r;
        assign exp_o[m]   = ex_r;
    end

endmodule

// File: rtl/mmap_xlate.sv
module mmap_xlate
    import mmap_pkg::*;
(
    input  map_pages_t [NUM_MAPS-1:0]   all_pages,
    input  logic [MAP_W-1:0]            map_sel,
    input  logic [LA_W-1:0]             laddr,
    output logic [PA_W-1:0]             paddr
);

    logic [PIDX_W-1:0] slot;

    assign slot  = laddr[LA_W-1 -: PIDX_W];
    assign paddr = {all_pages[map_sel][slot], laddr[PAGE_OFF-1:0]};

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import mmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sup,
    input  logic                io_wr,
    input  logic [MAP_W-1:0]    io_map,
    input  logic [WIN_AW-1:0]   io_addr,
    input  logic [1:0]          io_be,
    input  logic [BUS_W-1:0]    io_wdata,
    output logic [BUS_W-1:0]    io_rdata,
    output logic                bus_err,
    input  logic [MAP_W-1:0]    map_sel,
    input  logic [LA_W-1:0]     laddr,
    output logic [PA_W-1:0]     paddr
);

    map_pages_t [NUM_MAPS-1:0]          pages_q;
    logic [NUM_MAPS-1:0][EXP_W-1:0]     exp_q;
    wr_cmd_t                            cmd;
    map_pages_t                         nxt_pages;

    mmap_access u_access (
        .io_wr     (io_wr),
        .sup       (sup),
        .io_be     (io_be),
        .io_map    (io_map),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .cur_pages (pages_q[io_map]),
        .cur_exp   (exp_q[io_map]),
        .cmd       (cmd),
        .nxt_pages (nxt_pages),
        .io_rdata  (io_rdata),
        .bus_err   (bus_err)
    );

    mmap_store u_store (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .nxt_pages (nxt_pages),
        .pages_o   (pages_q),
        .exp_o     (exp_q)
    );

    mmap_xlate u_xlate (
        .all_pages (pages_q),
        .map_sel   (map_sel),
        .laddr     (laddr),
        .paddr     (paddr)
    );

endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk
    import mmap_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sup,
    input  logic                        io_wr,
    input  logic [MAP_W-1:0]            io_map,
    input  logic                        bus_err,
    input  logic [MAP_W-1:0]            map_sel,
    input  logic [LA_W-1:0]             laddr,
    input  logic [PA_W-1:0]             paddr,
    input  map_pages_t [NUM_MAPS-1:0]   all_pages
);

    logic [NUM_MAPS*PAGES*BYTE_W-1:0] hi_bytes;

    always_comb begin
        hi_bytes = '0;
        for (int m = 0; m < NUM_MAPS; m++)
            for (int p = 0; p < PAGES; p++)
                hi_bytes[(m*PAGES+p)*BYTE_W +: BYTE_W] = all_pages[m][p][PG_W-1:BYTE_W];
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (all_pages == '0));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        paddr[PAGE_OFF-1:0] == laddr[PAGE_OFF-1:0]);

    // R2
    page_pick_chk: assert property (@(posedge clk) disable iff (rst)
        paddr[PA_W-1:PAGE_OFF] == all_pages[map_sel][laddr[LA_W-1 -: PIDX_W]]);

    // R5
    user_hi_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !sup) |=> (hi_bytes == $past(hi_bytes)));

    // R6
    err_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> (all_pages == $past(all_pages)));

    // R11
    err_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
        !io_wr |-> !bus_err);

    for (genvar m = 0; m < NUM_MAPS; m++) begin : g_iso
        // R10
        map_isolated_chk: assert property (@(posedge clk) disable iff (rst)
            (io_wr && (io_map != MAP_W'(m))) |=> $stable(all_pages[m]));
    end

endmodule

bind page_mapper page_mapper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sup       (sup),
    .io_wr     (io_wr),
    .io_map    (io_map),
    .bus_err   (bus_err),
    .map_sel   (map_sel),
    .laddr     (laddr),
    .paddr     (paddr),
    .all_pages (pages_q)
);

// File: tb/test_page_mapper.sv
module test_page_mapper;
    import mmap_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                sup = 1'b1;
    logic                io_wr = 1'b0;
    logic [MAP_W-1:0]    io_map = '0;
    logic [WIN_AW-1:0]   io_addr = '0;
    logic [1:0]          io_be = '0;
    logic [BUS_W-1:0]    io_wdata = '0;
    logic [BUS_W-1:0]    io_rdata;
    logic                bus_err;
    logic [MAP_W-1:0]    map_sel = '0;
    logic [LA_W-1:0]     laddr = '0;
    logic [PA_W-1:0]     paddr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    page_mapper i_page_mapper (
        .clk(clk), .rst(rst), .sup(sup), .io_wr(io_wr), .io_map(io_map),
        .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .bus_err(bus_err), .map_sel(map_sel),
        .laddr(laddr), .paddr(paddr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one write strobe; err is sampled inside the strobe cycle
    task automatic bus_write(input logic [1:0] m, input logic [4:0] a,
                             input logic [1:0] be, input logic [15:0] d,
                             input logic s, output logic e);
        @(negedge clk);
        sup = s; io_map = m; io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
        #1 e = bus_err;
        @(negedge clk);
        io_wr = 1'b0; io_be = '0;
    endtask

    task automatic bus_read(input logic [1:0] m, input logic [4:0] a,
                            input logic s, output logic [15:0] d);
        @(negedge clk);
        sup = s; io_map = m; io_addr = a; io_wr = 1'b0;
        #1 d = io_rdata;
    endtask

    task automatic xlate(input logic [1:0] m, input logic [15:0] la,
                         output logic [PA_W-1:0] pa);
        @(negedge clk);
        map_sel = m; laddr = la;
        #1 pa = paddr;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        logic [PA_W-1:0] pa;
        for (int m = 0; m < NUM_MAPS; m++) begin
            bus_read(2'(m), 5'd16, 1'b1, d);
            chk(d == 16'h0, "R1 mask exp", {16'h0, d}, 32'h0);
            bus_read(2'(m), 5'd13, 1'b1, d);
            chk(d == 16'h0, "R1 page reg", {16'h0, d}, 32'h0);
        end
        xlate(2'd0, 16'hE123, pa);
        chk(pa == 29'h0123, "R1 R2 paddr", 32'(pa), 32'h0123);
    endtask

    task automatic t_packed_word;
        logic e;
        logic [15:0] d;
        bus_write(2'd0, 5'd16, 2'b01, 16'h0008, 1'b1, e);
        bus_write(2'd0, 5'd1, 2'b11, 16'hA55A, 1'b0, e);
        chk(e == 1'b0, "R3 legal word write err", {31'h0, e}, 32'h0);
        bus_read(2'd0, 5'd1, 1'b0, d);
        chk(d == 16'hA55A, "R3 packed readback", {16'h0, d}, 32'hA55A);
        bus_read(2'd0, 5'd10, 1'b1, d);
        chk(d == 16'h00A5, "R3 reg2 full", {16'h0, d}, 32'h00A5);
        bus_read(2'd0, 5'd11, 1'b1, d);
        chk(d == 16'h005A, "R3 reg3 full", {16'h0, d}, 32'h005A);
    endtask

    task automatic t_byte_lanes;
        logic e;
        logic [15:0] d;
        bus_write(2'd0, 5'd1, 2'b10, 16'h3C00, 1'b0, e);
        bus_read(2'd0, 5'd1, 1'b0, d);
        chk(d == 16'h3C5A, "R4 high lane merge", {16'h0, d}, 32'h3C5A);
        bus_write(2'd0, 5'd1, 2'b01, 16'hFF77, 1'b0, e);
        bus_read(2'd0, 5'd1, 1'b0, d);
        chk(d == 16'h3C77, "R4 low lane merge", {16'h0, d}, 32'h3C77);
    endtask

    task automatic t_translate;
        logic [PA_W-1:0] pa;
        xlate(2'd0, 16'h5ABC, pa);
        chk(pa == {16'h003C, 13'h1ABC}, "R2 translate", 32'(pa), 32'({16'h003C, 13'h1ABC}));
    endtask

    task automatic t_mask_violation;
        logic e;
        logic [15:0] d;
        bus_write(2'd0, 5'd16, 2'b01, 16'h0004, 1'b1, e);
        bus_write(2'd0, 5'd1, 2'b11, 16'h1F0F, 1'b0, e);
        chk(e == 1'b1, "R6 bit 4 set raises err", {31'h0, e}, 32'h1);
        bus_read(2'd0, 5'd1, 1'b0, d);
        chk(d == 16'h3C77, "R6 rejected write no change", {16'h0, d}, 32'h3C77);
        bus_write(2'd0, 5'd1, 2'b11, 16'h0F0E, 1'b0, e);
        chk(e == 1'b0, "R6 bits below 4 no err", {31'h0, e}, 32'h0);
        bus_read(2'd0, 5'd1, 1'b0, d);
        chk(d == 16'h0F0E, "R6 legal write commits", {16'h0, d}, 32'h0F0E);
    endtask

    task automatic t_super_override;
        logic e;
        logic [15:0] d;
        bus_write(2'd0, 5'd10, 2'b10, 16'hBE00, 1'b1, e);
        bus_read(2'd0, 5'd10, 1'b1, d);
        chk(d == 16'hBE0F, "R7 sup high lane", {16'h0, d}, 32'hBE0F);
        bus_write(2'd0, 5'd1, 2'b11, 16'h1F1F, 1'b1, e);
        chk(e == 1'b0, "R7 sup ignores mask", {31'h0, e}, 32'h0);
        bus_read(2'd0, 5'd10, 1'b1, d);
        chk(d == 16'hBE1F, "R7 sup packed write", {16'h0, d}, 32'hBE1F);
        bus_write(2'd0, 5'd1, 2'b11, 16'h0505, 1'b0, e);
        bus_read(2'd0, 5'd10, 1'b1, d);
        chk(d == 16'hBE05, "R5 user keeps high byte", {16'h0, d}, 32'hBE05);
    endtask

    task automatic t_user_priv;
        logic e;
        logic [15:0] d;
        bus_write(2'd0, 5'd10, 2'b11, 16'h0001, 1'b0, e);
        chk(e == 1'b1, "R8 user full write err", {31'h0, e}, 32'h1);
        bus_read(2'd0, 5'd10, 1'b1, d);
        chk(d == 16'hBE05, "R8 full reg unchanged", {16'h0, d}, 32'hBE05);
        bus_write(2'd0, 5'd16, 2'b01, 16'h0010, 1'b0, e);
        chk(e == 1'b1, "R8 user mask write err", {31'h0, e}, 32'h1);
        bus_read(2'd0, 5'd16, 1'b1, d);
        chk(d == 16'h0004, "R8 mask unchanged", {16'h0, d}, 32'h0004);
        bus_read(2'd0, 5'd10, 1'b0, d);
        chk(d == 16'h0000, "R5 user full read zero", {16'h0, d}, 32'h0);
    endtask

    task automatic t_mask_sat;
        logic e;
        logic [15:0] d;
        bus_write(2'd1, 5'd16, 2'b01, 16'h00FF, 1'b1, e);
        bus_read(2'd1, 5'd16, 1'b1, d);
        chk(d == 16'h0010, "R9 exp saturates", {16'h0, d}, 32'h0010);
        bus_write(2'd1, 5'd0, 2'b11, 16'hFFFF, 1'b0, e);
        chk(e == 1'b0, "R9 open slice no err", {31'h0, e}, 32'h0);
    endtask

    task automatic t_maps_independent;
        logic [15:0] d;
        logic [PA_W-1:0] pa;
        bus_read(2'd1, 5'd0, 1'b0, d);
        chk(d == 16'hFFFF, "R10 map1 written", {16'h0, d}, 32'hFFFF);
        bus_read(2'd0, 5'd0, 1'b0, d);
        chk(d == 16'h0000, "R10 map0 word0 untouched", {16'h0, d}, 32'h0);
        bus_read(2'd2, 5'd1, 1'b1, d);
        chk(d == 16'h0000, "R10 map2 untouched", {16'h0, d}, 32'h0);
        xlate(2'd1, 16'h0000, pa);
        chk(pa == {16'h00FF, 13'h0}, "R10 map_sel 1", 32'(pa), 32'({16'h00FF, 13'h0}));
        xlate(2'd0, 16'h0000, pa);
        chk(pa == 29'h0, "R10 map_sel 0", 32'(pa), 32'h0);
    endtask

    task automatic t_idle_err;
        @(negedge clk);
        sup = 1'b0; io_map = 2'd0; io_addr = 5'd10; io_be = 2'b11;
        io_wdata = 16'hFFFF; io_wr = 1'b0;
        #1 chk(bus_err == 1'b0, "R11 no strobe no err", {31'h0, bus_err}, 32'h0);
        io_be = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_packed_word();
        t_byte_lanes();
        t_translate();
        t_mask_violation();
        t_super_override();
        t_user_priv();
        t_mask_sat();
        t_maps_independent();
        t_idle_err();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule